// File: doc/BRIEF.md
# Transceiver Attribute Mailbox Access Engine

This block performs one attribute access to a transceiver through a pair of mailbox registers. One register takes commands and the other returns status. A local client hands over a 32-bit command word, an optional extra poll condition and a poll budget. The engine then runs the whole handshake on a memory-mapped bus. It writes the command with the request flag raised and polls status until the acknowledge flag is high. It keeps the upper half of that status word. It then writes the same command with the request flag lowered and polls until the acknowledge flag drops. Finally it reports completion together with the captured 16-bit value.

The bus side is a single-outstanding master with read, write and wait-request handshakes. Each poll phase is bounded by a limit on the number of status reads. If that limit runs out, the engine flags an error. After a failed first phase it still issues the lowering write, so the mailbox is left idle.

Top module: `xcvr_mbox_engine`

## Requirements
- R1: After reset, and whenever idle, `busy` and `done` are low and neither `bus_read` nor `bus_write` is asserted.
- R2: A `req_valid` seen while idle starts an access. The first bus write goes to the command address with `bus_wdata` equal to `req_cmd` with bit 15 forced to 1.
- R3: After each command write, the engine reads the status address repeatedly. It never issues a new read before the response of the previous read (`bus_rvalid`) has arrived.
- R4: The first poll phase ends on a status word with bit 15 = 1 that also satisfies `(sts & xmask) == (xval & xmask)`. Bits 31:16 of that word become `rsp_data`.
- R5: The second write goes to the command address with `req_cmd` and bit 15 forced to 0.
- R6: The second poll phase ends on a status word with bit 15 = 0 that also satisfies the same extra mask/value condition.
- R7: On success, `done` is high for exactly one cycle, with `rsp_err` = 0 and `rsp_data` valid. `busy` stays high from acceptance until that cycle.
- R8: A `req_valid` while busy is ignored: it starts no access and does not alter the running command.
- R9: If the first phase sees `poll_limit` non-matching reads (a limit of 0 acts as 1), the engine sets `rsp_err`, returns `rsp_data` = 0, and still performs the clearing write and the second poll phase.
- R10: If the second phase sees `poll_limit` non-matching reads, the engine ends with `rsp_err` = 1, keeping any data captured in the first phase.
- R11: While `bus_waitreq` is high, an asserted `bus_write` or `bus_read` stays asserted with unchanged address and write data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Start request from the local client |
| req_cmd | input | 32 | Command word (bit 15 is overridden by the engine) |
| req_xmask | input | 32 | Extra status bits that must match during polling |
| req_xval | input | 32 | Required values of the masked status bits |
| poll_limit | input | LIMW | Maximum status reads per poll phase |
| busy | output | 1 | Access in progress |
| done | output | 1 | One-cycle completion pulse |
| rsp_data | output | 16 | Captured upper half of the acknowledging status word |
| rsp_err | output | 1 | A poll phase ran out of its budget |
| bus_addr | output | AW | Bus address |
| bus_write | output | 1 | Bus write request |
| bus_read | output | 1 | Bus read request |
| bus_wdata | output | 32 | Bus write data |
| bus_waitreq | input | 1 | Slave stall; request held while high |
| bus_rdata | input | 32 | Read data |
| bus_rvalid | input | 1 | Read data valid |

## Verification
Two events can land on the same status response. The acknowledge flag can reach its expected value on the very read that also exhausts the poll budget. A stalled bus can also coincide with the moment a new local request arrives. The bench provokes the first event by setting the slave's acknowledge delay equal to the poll limit, and the second by pulsing `req_valid` mid-access with wait states enabled. A match on the last permitted read must count as success with no error, and the stray request must leave the logged write sequence unchanged.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  localparam int unsigned MBOX_DW = 32;
  localparam int unsigned MBOX_RW = 16;

  typedef enum logic [2:0] {
    S_IDLE, S_WR_SET, S_RD_SET, S_WT_SET,
    S_WR_CLR, S_RD_CLR, S_WT_CLR, S_DONE
  } mbox_state_e;

  // command word with the request flag forced to a given level
  function automatic logic [MBOX_DW-1:0] mbox_cmd_word(
    input logic [MBOX_DW-1:0] cmd, input logic flag, input int unsigned pos);
    logic [MBOX_DW-1:0] w;
    w = cmd;
    w[pos] = flag;
    return w;
  endfunction

  // status word meets the expected acknowledge level and the extra condition
  function automatic logic mbox_hit(
    input logic [MBOX_DW-1:0] sts, input logic [MBOX_DW-1:0] xmask,
    input logic [MBOX_DW-1:0] xval, input logic want, input int unsigned pos);
    return ((sts & xmask) == (xval & xmask)) && (sts[pos] == want);
  endfunction
endpackage

// File: rtl/mbox_poll_match.sv
module mbox_poll_match
  import mbox_pkg::*;
#(
  parameter int unsigned REQ_BIT = 15
) (
  input  logic [MBOX_DW-1:0] sts,
  input  logic [MBOX_DW-1:0] xmask,
  input  logic [MBOX_DW-1:0] xval,
  input  logic               want,
  output logic               hit
);
  always_comb hit = mbox_hit(sts, xmask, xval, want, REQ_BIT);
endmodule

// File: rtl/mbox_poll_timer.sv
module mbox_poll_timer #(
  parameter int unsigned LIMW = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            restart,
  input  logic            miss,
  input  logic [LIMW-1:0] limit,
  output logic            expire
);
  localparam int unsigned CW = LIMW + 1;
  logic [LIMW-1:0] miss_cnt;
  logic [CW-1:0]   next_cnt;

  always_comb begin
    next_cnt = {1'b0, miss_cnt} + CW'(1);
    expire   = miss && (next_cnt >= {1'b0, limit});
  end

  always_ff @(posedge clk) begin
    if (!rst_n || restart) miss_cnt <= '0;
    else if (miss && !expire) miss_cnt <= next_cnt[LIMW-1:0];
  end
endmodule

// File: rtl/xcvr_mbox_engine.sv
module xcvr_mbox_engine
  import mbox_pkg::*;
#(
  parameter int unsigned AW       = 20,
  parameter logic [AW-1:0] CMD_ADDR = 20'hA403C,
  parameter logic [AW-1:0] STS_ADDR = 20'hA4040,
  parameter int unsigned REQ_BIT  = 15,
  parameter int unsigned LIMW     = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic [MBOX_DW-1:0] req_cmd,
  input  logic [MBOX_DW-1:0] req_xmask,
  input  logic [MBOX_DW-1:0] req_xval,
  input  logic [LIMW-1:0]    poll_limit,
  output logic               busy,
  output logic               done,
  output logic [MBOX_RW-1:0] rsp_data,
  output logic               rsp_err,
  output logic [AW-1:0]      bus_addr,
  output logic               bus_write,
  output logic               bus_read,
  output logic [MBOX_DW-1:0] bus_wdata,
  input  logic               bus_waitreq,
  input  logic [MBOX_DW-1:0] bus_rdata,
  input  logic               bus_rvalid
);
  localparam int unsigned HI_LSB = MBOX_DW - MBOX_RW;

  mbox_state_e        state, state_nx;
  logic [MBOX_DW-1:0] cmd_q, xmask_q, xval_q;
  logic [LIMW-1:0]    lim_q;
  logic [MBOX_RW-1:0] data_q;
  logic               err_q;

  // named events used by the logic and the assertions
  logic set_phase, wr_done, rd_issue, rsp_ev, hit, miss_ev, expire, accept;

  always_comb begin
    set_phase = (state == S_WR_SET) || (state == S_RD_SET) || (state == S_WT_SET);
    bus_write = (state == S_WR_SET) || (state == S_WR_CLR);
    bus_read  = (state == S_RD_SET) || (state == S_RD_CLR);
    bus_addr  = bus_write ? CMD_ADDR : STS_ADDR;
    bus_wdata = mbox_cmd_word(cmd_q, set_phase, REQ_BIT);
    wr_done   = bus_write && !bus_waitreq;
    rd_issue  = bus_read && !bus_waitreq;
    rsp_ev    = bus_rvalid && ((state == S_WT_SET) || (state == S_WT_CLR));
    miss_ev   = rsp_ev && !hit;
    accept    = (state == S_IDLE) && req_valid;
    busy      = (state != S_IDLE);
    done      = (state == S_DONE);
    rsp_data  = data_q;
    rsp_err   = err_q;
  end

  mbox_poll_match #(.REQ_BIT(REQ_BIT)) u_match (
    .sts(bus_rdata), .xmask(xmask_q), .xval(xval_q), .want(set_phase), .hit(hit)
  );

  mbox_poll_timer #(.LIMW(LIMW)) u_timer (
    .clk(clk), .rst_n(rst_n), .restart(wr_done), .miss(miss_ev),
    .limit(lim_q), .expire(expire)
  );

  always_comb begin
    state_nx = state;
    case (state)
      S_IDLE:   if (req_valid) state_nx = S_WR_SET;
      S_WR_SET: if (wr_done) state_nx = S_RD_SET;
      S_RD_SET: if (rd_issue) state_nx = S_WT_SET;
      S_WT_SET: if (rsp_ev) state_nx = (hit || expire) ? S_WR_CLR : S_RD_SET;
      S_WR_CLR: if (wr_done) state_nx = S_RD_CLR;
      S_RD_CLR: if (rd_issue) state_nx = S_WT_CLR;
      S_WT_CLR: if (rsp_ev) state_nx = (hit || expire) ? S_DONE : S_RD_CLR;
      default:  state_nx = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      cmd_q   <= '0;
      xmask_q <= '0;
      xval_q  <= '0;
      lim_q   <= '0;
      data_q  <= '0;
      err_q   <= 1'b0;
    end else begin
      state <= state_nx;
      if (accept) begin
        cmd_q   <= req_cmd;
        xmask_q <= req_xmask;
        xval_q  <= req_xval;
        lim_q   <= poll_limit;
        data_q  <= '0;
        err_q   <= 1'b0;
      end
      if (rsp_ev && set_phase && hit) data_q <= bus_rdata[MBOX_DW-1:HI_LSB];
      if (miss_ev && expire) err_q <= 1'b1;
    end
  end

  // ---------------- assertions ----------------
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!bus_read && !bus_write));

  p_first_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (bus_write && bus_wdata[REQ_BIT] && bus_addr == CMD_ADDR));

  p_single_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_issue |=> !bus_read);

  p_clear_after_ack_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_ev && set_phase && hit) |=> (bus_write && !bus_wdata[REQ_BIT]));

  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && !busy));

  p_cmd_locked_r8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(cmd_q));

  p_clear_on_timeout_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (miss_ev && expire && set_phase) |=> (bus_write && !bus_wdata[REQ_BIT] && rsp_err));

  p_hold_write_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_write && bus_waitreq) |=> (bus_write && $stable(bus_wdata) && $stable(bus_addr)));

  p_hold_read_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_read && bus_waitreq) |=> (bus_read && $stable(bus_addr)));
endmodule

// File: tb/xcvr_mbox_engine_bench.sv
module xcvr_mbox_engine_bench;
  localparam int CLK_PERIOD = 10;
  localparam logic [19:0] CMD_A = 20'hA403C;
  localparam logic [19:0] STS_A = 20'hA4040;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [31:0] req_cmd = '0, req_xmask = '0, req_xval = '0;
  logic [15:0] poll_limit = 16'd50;
  logic        busy, done, rsp_err, bus_write, bus_read, bus_waitreq, bus_rvalid;
  logic [15:0] rsp_data;
  logic [19:0] bus_addr;
  logic [31:0] bus_wdata, bus_rdata;

  always #(CLK_PERIOD/2) clk = ~clk;

  xcvr_mbox_engine u_xcvr_mbox_engine (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_cmd(req_cmd),
    .req_xmask(req_xmask), .req_xval(req_xval), .poll_limit(poll_limit),
    .busy(busy), .done(done), .rsp_data(rsp_data), .rsp_err(rsp_err),
    .bus_addr(bus_addr), .bus_write(bus_write), .bus_read(bus_read),
    .bus_wdata(bus_wdata), .bus_waitreq(bus_waitreq), .bus_rdata(bus_rdata),
    .bus_rvalid(bus_rvalid)
  );

  // ---------------- mailbox slave model ----------------
  int          ws = 0, ack_after = 1, clr_after = 1, b14_busy = 0;
  logic [15:0] data_hi = 16'h0;
  int          wcnt = 0, nrd = 0;
  logic        phase_set = 1'b0, sts_ack = 1'b0;
  logic        rvalid_r = 1'b0;
  logic [31:0] rdata_r = '0;
  int          nwr = 0, rd_set = 0, rd_clr = 0, overlap = 0, hold_err = 0, bad_addr = 0;
  logic [31:0] wr_log [0:7];
  logic        hold_pend = 1'b0, hold_wr = 1'b0;
  logic [19:0] hold_addr = '0;
  logic [31:0] hold_data = '0;

  assign bus_waitreq = (bus_read || bus_write) && (wcnt < ws);
  assign bus_rvalid  = rvalid_r;
  assign bus_rdata   = rdata_r;

  always @(posedge clk) begin
    rvalid_r <= 1'b0;
    if (hold_pend) begin
      if ((hold_wr ? !bus_write : !bus_read) || bus_addr != hold_addr ||
          (hold_wr && bus_wdata != hold_data)) hold_err++;
    end
    hold_pend = rst_n && (bus_read || bus_write) && bus_waitreq;
    hold_wr = bus_write; hold_addr = bus_addr; hold_data = bus_wdata;
    if (!rst_n) begin
      wcnt = 0;
    end else if (bus_read || bus_write) begin
      if (wcnt < ws) wcnt++;
      else begin
        wcnt = 0;
        if (bus_write) begin
          if (bus_addr != CMD_A) bad_addr++;
          if (nwr < 8) wr_log[nwr] = bus_wdata;
          nwr++;
          nrd = 0;
          phase_set = bus_wdata[15];
        end else begin
          if (bus_addr != STS_A) bad_addr++;
          if (rvalid_r) overlap++;
          nrd++;
          if (phase_set) begin
            rd_set++;
            if (nrd >= ack_after) sts_ack = 1'b1;
          end else begin
            rd_clr++;
            if (nrd >= clr_after) sts_ack = 1'b0;
          end
          rvalid_r <= 1'b1;
          rdata_r  <= {data_hi, sts_ack, (nrd <= b14_busy), 14'h00A5};
        end
      end
    end
  end

  // ---------------- bookkeeping ----------------
  int  n_chk = 0, n_fail = 0;
  bit  finished = 1'b0;
  logic [15:0] got_data;
  logic        got_err, got_done;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic clear_log();
    nwr = 0; rd_set = 0; rd_clr = 0; overlap = 0; hold_err = 0; bad_addr = 0;
  endtask

  task automatic run_access(input logic [31:0] cmd, input logic [31:0] xm,
                            input logic [31:0] xv, input logic [15:0] lim);
    clear_log();
    got_done = 1'b0;
    @(negedge clk);
    req_cmd = cmd; req_xmask = xm; req_xval = xv; poll_limit = lim; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    for (int i = 0; i < 3000 && !got_done; i++) begin
      if (done) begin got_done = 1'b1; got_data = rsp_data; got_err = rsp_err; end
      else @(negedge clk);
    end
    chk(got_done, "R7 done seen", got_done, 1);
    @(negedge clk);
    chk(!done && !busy, "R7 done single cycle", {done, busy}, 0);
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset();
    chk(!busy && !done, "R1 reset busy/done", {busy, done}, 0);
    chk(!bus_read && !bus_write, "R1 reset bus idle", {bus_read, bus_write}, 0);
  endtask

  task automatic t_basic();
    ack_after = 3; clr_after = 2; b14_busy = 0; data_hi = 16'hBEEF; ws = 0;
    run_access(32'h0002_004A, 32'h0, 32'h0, 16'd50);
    chk(nwr == 2, "R2 write count", nwr, 2);
    chk(wr_log[0] == 32'h0002_804A, "R2 set write data", wr_log[0], 32'h0002_804A);
    chk(wr_log[1] == 32'h0002_004A, "R5 clear write data", wr_log[1], 32'h0002_004A);
    chk(bad_addr == 0, "R2 mailbox addresses", bad_addr, 0);
    chk(rd_set == 3, "R3 set-phase reads", rd_set, 3);
    chk(overlap == 0, "R3 single outstanding", overlap, 0);
    chk(rd_clr == 2, "R6 clear-phase reads", rd_clr, 2);
    chk(got_data == 16'hBEEF, "R4 captured data", got_data, 16'hBEEF);
    chk(!got_err, "R7 no error", got_err, 0);
    chk(!bus_read && !bus_write, "R1 idle after done", {bus_read, bus_write}, 0);
  endtask

  task automatic t_mask();
    ack_after = 1; clr_after = 1; b14_busy = 3; data_hi = 16'h1234; ws = 0;
    run_access(32'h0006_A040, 32'h0000_4000, 32'h0, 16'd50);
    chk(wr_log[0] == 32'h0006_A040, "R2 flag already set", wr_log[0], 32'h0006_A040);
    chk(wr_log[1] == 32'h0006_2040, "R5 flag cleared", wr_log[1], 32'h0006_2040);
    chk(rd_set == 4, "R4 extra mask set phase", rd_set, 4);
    chk(rd_clr == 4, "R6 extra mask clear phase", rd_clr, 4);
    chk(got_data == 16'h1234 && !got_err, "R4 data with mask", got_data, 16'h1234);
  endtask

  task automatic t_waitstates_ignore();
    ack_after = 2; clr_after = 2; b14_busy = 0; data_hi = 16'h0F0F; ws = 2;
    clear_log();
    got_done = 1'b0;
    @(negedge clk);
    req_cmd = 32'h0000_000D; req_xmask = 0; req_xval = 0; poll_limit = 16'd50; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    repeat (3) @(negedge clk);
    req_cmd = 32'h0000_0777; req_valid = 1'b1;   // stray request while busy
    @(negedge clk);
    req_valid = 1'b0;
    for (int i = 0; i < 3000 && !got_done; i++) begin
      if (done) begin got_done = 1'b1; got_data = rsp_data; got_err = rsp_err; end
      else @(negedge clk);
    end
    chk(got_done, "R7 done with wait states", got_done, 1);
    repeat (3) @(negedge clk);
    chk(nwr == 2, "R8 stray request ignored (writes)", nwr, 2);
    chk(wr_log[0] == 32'h0000_800D && wr_log[1] == 32'h0000_000D, "R8 command unchanged",
        wr_log[1], 32'h0000_000D);
    chk(!busy, "R8 no second access", busy, 0);
    chk(hold_err == 0, "R11 request held under stall", hold_err, 0);
    chk(got_data == 16'h0F0F, "R4 data with wait states", got_data, 16'h0F0F);
    ws = 0;
  endtask

  task automatic t_limit_edge();
    ack_after = 4; clr_after = 1; b14_busy = 0; data_hi = 16'hA5A5; ws = 0;
    run_access(32'h0000_0049, 32'h0, 32'h0, 16'd4);
    chk(!got_err && got_data == 16'hA5A5, "R9 match on last allowed read", got_err, 0);
    chk(rd_set == 4, "R9 reads at limit", rd_set, 4);
  endtask

  task automatic t_tmo_set();
    ack_after = 1000; clr_after = 1; b14_busy = 0; data_hi = 16'h5555; ws = 0;
    run_access(32'h0000_0041, 32'h0, 32'h0, 16'd5);
    chk(got_err, "R9 error flag", got_err, 1);
    chk(got_data == 16'h0, "R9 data zero", got_data, 0);
    chk(rd_set == 5, "R9 reads before abort", rd_set, 5);
    chk(nwr == 2 && wr_log[1] == 32'h0000_0041, "R9 clearing write issued", wr_log[1], 32'h41);
    chk(rd_clr == 1, "R9 clear phase polled", rd_clr, 1);
  endtask

  task automatic t_tmo_zero_limit();
    ack_after = 1000; clr_after = 1; data_hi = 16'h0; ws = 0;
    run_access(32'h0000_0041, 32'h0, 32'h0, 16'd0);
    chk(got_err && rd_set == 1, "R9 zero limit acts as one", rd_set, 1);
  endtask

  task automatic t_tmo_clr();
    ack_after = 2; clr_after = 1000; data_hi = 16'h7E57; ws = 0;
    run_access(32'h0000_004C, 32'h0, 32'h0, 16'd3);
    chk(got_err, "R10 error flag", got_err, 1);
    chk(got_data == 16'h7E57, "R10 data kept", got_data, 16'h7E57);
    chk(rd_clr == 3, "R10 clear reads before abort", rd_clr, 3);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_basic();
    t_mask();
    t_waitstates_ignore();
    t_limit_edge();
    t_tmo_set();
    t_tmo_zero_limit();
    t_tmo_clr();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      finished = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual 0x0 expected 0x1");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule